// File: doc/BRIEF.md
# Bit-Plane Frame Memory with Serial Video Port

This block holds one bit plane of a frame buffer as a square array of single bits. The default is 256 rows by 256 columns, and both sizes are parameters so a test build can be smaller. It has two ports that share the array.

The random port reads or writes one bit at a time. It also accepts a rectangle command that paints an inclusive region with a constant 0 or 1. A sequencer carries out the rectangle one row per cycle, writing only the selected columns of that row through a write mask.

The video port copies a whole row into a serial register in a single cycle. It then emits that row one bit per shift strobe, starting at column 0. A flag asks for the next row once the last bit has gone out.

The array allows one access per cycle, and the ports compete for it in a fixed order:

1. A row copy to the serial register.
2. A rectangle step.
3. A single-bit access.

A single-bit request that loses must be held by the requester until it is granted. Read data arrives in the cycle after the grant.

Top module: `frame_plane_mem`

## Requirements
- R1: After reset, `fill_busy` is 0, `acc_rvalid` is 0 and `xfer_flag` is 1, where 1 means the serial register is empty.
- R2: A granted random write with `acc_we`=1 changes only the bit at row `acc_row`, column `acc_col`, to `acc_wdata`. Every other bit keeps its value.
- R3: A granted random read with `acc_we`=0 sets `acc_rvalid` to 1 in the following cycle, with `acc_rdata` equal to the addressed bit. `acc_rvalid` is 0 in every other cycle.
- R4: A rectangle command sets every bit in rows min(y0,y1)..max(y0,y1) and columns min(x0,x1)..max(x0,x1) to `fill_val`, both ranges inclusive. Bits outside that region are unchanged, and the corners may be given in either order.
- R5: `fill_busy` rises in the cycle after `fill_start` is accepted. Without interruption it stays high for exactly as many cycles as the rectangle has rows, writing one row per cycle from the lowest row upward.
- R6: A `fill_start` while `fill_busy` is 1 is ignored. The command in progress completes unchanged, and the ignored region is not written.
- R7: `acc_grant` is 1 only when `acc_req` is 1, `xfer_req` is 0 and `fill_busy` is 0. A random write requested during a rectangle therefore takes effect after the rectangle, overriding the painted value.
- R8: `xfer_req` always wins the array. A row copy during a rectangle pauses it for one cycle, so `fill_busy` lasts one extra cycle. A random request in the same cycle as a row copy is granted in a later cycle.
- R9: A row copy of row `xfer_row` makes `vid_out` show that row's column 0 in the next cycle. Each cycle with `shift_en`=1 advances `vid_out` to the next higher column.
- R10: `xfer_flag` drops to 0 in the cycle after a row copy and returns to 1 after the number of shifts equals the number of columns. With `xfer_flag`=1, `shift_en` leaves `vid_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Single-bit access request, held until granted |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_row | input | ROW_BITS | Row of the bit to access |
| acc_col | input | COL_BITS | Column of the bit to access |
| acc_wdata | input | 1 | Bit to write |
| acc_grant | output | 1 | Access performed this cycle |
| acc_rdata | output | 1 | Read result |
| acc_rvalid | output | 1 | `acc_rdata` is valid |
| fill_start | input | 1 | Start a rectangle command |
| fill_x0 | input | COL_BITS | First corner column |
| fill_y0 | input | ROW_BITS | First corner row |
| fill_x1 | input | COL_BITS | Second corner column |
| fill_y1 | input | ROW_BITS | Second corner row |
| fill_val | input | 1 | Value painted into the region |
| fill_busy | output | 1 | Rectangle in progress |
| xfer_req | input | 1 | Copy a row to the serial register this cycle |
| xfer_row | input | ROW_BITS | Row to copy |
| shift_en | input | 1 | Shift strobe for the serial register |
| vid_out | output | 1 | Serial video bit |
| xfer_flag | output | 1 | Serial register empty; next row wanted |

## Verification
The assertions take for granted several things about the inputs:

- A random request is held steady until it is granted.
- `xfer_req` is a one-cycle pulse.
- The corner and value inputs are stable in the cycle where `fill_start` is sampled.

The stimulus meets these by driving every input at the falling edge. Requests are kept up until `acc_grant` is seen, and row copies and rectangle starts are single-cycle pulses. Shifting continues only for as many strobes as the row has columns, apart from one deliberate run of strobes on an empty register.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_XFER = 2'd1,
    OP_FILL = 2'd2,
    OP_RAND = 2'd3
  } op_e;

  // fixed priority: row copy, then rectangle step, then single-bit access
  function automatic op_e pick_op(input logic want_xfer,
                                  input logic want_fill,
                                  input logic want_rand);
    if (want_xfer)      return OP_XFER;
    else if (want_fill) return OP_FILL;
    else if (want_rand) return OP_RAND;
    else                return OP_IDLE;
  endfunction

endpackage

// File: rtl/fpm_array.sv
module fpm_array #(
  parameter int ROWS = 256,
  parameter int COLS = 256,
  localparam int RW = $clog2(ROWS)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [RW-1:0]   wr_row,
  input  logic [COLS-1:0] wr_mask,
  input  logic [COLS-1:0] wr_data,
  input  logic [RW-1:0]   rd_row,
  output logic [COLS-1:0] rd_data
);

  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en)
      cells[wr_row] <= (cells[wr_row] & ~wr_mask) | (wr_data & wr_mask);
  end

  assign rd_data = cells[rd_row];

endmodule

// File: rtl/fpm_fill.sv
module fpm_fill #(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 8,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [COL_BITS-1:0] x0,
  input  logic [ROW_BITS-1:0] y0,
  input  logic [COL_BITS-1:0] x1,
  input  logic [ROW_BITS-1:0] y1,
  input  logic                val,
  input  logic                stall,
  output logic                busy,
  output logic                step,
  output logic [ROW_BITS-1:0] step_row,
  output logic [COLS-1:0]     step_mask,
  output logic [COLS-1:0]     step_data
);

  function automatic logic [COLS-1:0] span_mask(input logic [COL_BITS-1:0] lo,
                                                input logic [COL_BITS-1:0] hi);
    logic [COLS-1:0] m;
    for (int i = 0; i < COLS; i++)
      m[i] = (i >= int'(lo)) && (i <= int'(hi));
    return m;
  endfunction

  logic [ROW_BITS-1:0] cur_y, top_y;
  logic [COL_BITS-1:0] lo_x, hi_x;
  logic                pval;
  logic                accept, last_row;

  assign accept   = start && !busy;
  assign step     = busy && !stall;
  assign last_row = (cur_y == top_y);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cur_y <= '0;
      top_y <= '0;
      lo_x  <= '0;
      hi_x  <= '0;
      pval  <= 1'b0;
    end else if (accept) begin
      busy  <= 1'b1;
      cur_y <= (y0 < y1) ? y0 : y1;
      top_y <= (y0 < y1) ? y1 : y0;
      lo_x  <= (x0 < x1) ? x0 : x1;
      hi_x  <= (x0 < x1) ? x1 : x0;
      pval  <= val;
    end else if (step) begin
      if (last_row) busy  <= 1'b0;
      else          cur_y <= cur_y + 1'b1;
    end
  end

  assign step_row  = cur_y;
  assign step_mask = span_mask(lo_x, hi_x);
  assign step_data = {COLS{pval}};

  // R5: each step moves to the next row unless it was the last
  assert_row_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !last_row |=> busy && (cur_y == $past(cur_y) + 1'b1));
  // R5: the step on the top row ends the command
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step && last_row |=> !busy);
  // R8: a stalled cycle holds the walker in place
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && stall |=> busy && $stable(cur_y));
  // R6: a start during a command does not reload the region
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(top_y) && $stable(lo_x) && $stable(hi_x));

endmodule

// File: rtl/fpm_serial.sv
module fpm_serial #(
  parameter int COLS = 256,
  localparam int CW = $clog2(COLS) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [COLS-1:0] row_in,
  input  logic            shift_en,
  output logic            vid_out,
  output logic            empty
);

  logic [COLS-1:0] sreg;
  logic [CW-1:0]   left;
  logic            do_shift;

  assign do_shift = shift_en && !load && (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg  <= '0;
      left  <= '0;
      empty <= 1'b1;
    end else if (load) begin
      sreg  <= row_in;
      left  <= CW'(COLS);
      empty <= 1'b0;
    end else if (do_shift) begin
      sreg  <= sreg >> 1;
      left  <= left - 1'b1;
      if (left == CW'(1)) empty <= 1'b1;
    end
  end

  assign vid_out = sreg[0];

  // R10: the flag only rises as a result of a shift strobe
  assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(shift_en));
  // R10: a row copy clears the flag
  assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !empty);
  // R10: strobes on an empty register change nothing
  assert_empty_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !load |=> $stable(vid_out) && empty);

endmodule

// File: rtl/frame_plane_mem.sv
module frame_plane_mem
  import fpm_pkg::*;
#(
  parameter int ROW_BITS = 8,
  parameter int COL_BITS = 8,
  localparam int ROWS = 1 << ROW_BITS,
  localparam int COLS = 1 << COL_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_req,
  input  logic                acc_we,
  input  logic [ROW_BITS-1:0] acc_row,
  input  logic [COL_BITS-1:0] acc_col,
  input  logic                acc_wdata,
  output logic                acc_grant,
  output logic                acc_rdata,
  output logic                acc_rvalid,
  input  logic                fill_start,
  input  logic [COL_BITS-1:0] fill_x0,
  input  logic [ROW_BITS-1:0] fill_y0,
  input  logic [COL_BITS-1:0] fill_x1,
  input  logic [ROW_BITS-1:0] fill_y1,
  input  logic                fill_val,
  output logic                fill_busy,
  input  logic                xfer_req,
  input  logic [ROW_BITS-1:0] xfer_row,
  input  logic                shift_en,
  output logic                vid_out,
  output logic                xfer_flag
);

  // named internal events
  op_e                 op;
  logic                fill_step;
  logic [ROW_BITS-1:0] fill_row;
  logic [COLS-1:0]     fill_mask, fill_data;
  logic                rand_wr, rand_rd;

  logic                wr_en;
  logic [ROW_BITS-1:0] wr_row, rd_row;
  logic [COLS-1:0]     wr_mask, wr_data, rd_data;

  fpm_fill #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_start),
    .x0(fill_x0), .y0(fill_y0), .x1(fill_x1), .y1(fill_y1), .val(fill_val),
    .stall(xfer_req), .busy(fill_busy), .step(fill_step),
    .step_row(fill_row), .step_mask(fill_mask), .step_data(fill_data)
  );

  assign op        = pick_op(xfer_req, fill_busy, acc_req && !fill_busy);
  assign acc_grant = (op == OP_RAND);
  assign rand_wr   = acc_grant && acc_we;
  assign rand_rd   = acc_grant && !acc_we;

  always_comb begin
    wr_en   = 1'b0;
    wr_row  = fill_row;
    wr_mask = fill_mask;
    wr_data = fill_data;
    if (op == OP_FILL) begin
      wr_en = 1'b1;
    end else if (rand_wr) begin
      wr_en   = 1'b1;
      wr_row  = acc_row;
      wr_mask = COLS'(1) << acc_col;
      wr_data = {COLS{acc_wdata}};
    end
  end

  assign rd_row = xfer_req ? xfer_row : acc_row;

  fpm_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
    .clk(clk), .wr_en(wr_en), .wr_row(wr_row), .wr_mask(wr_mask),
    .wr_data(wr_data), .rd_row(rd_row), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_rvalid <= 1'b0;
      acc_rdata  <= 1'b0;
    end else begin
      acc_rvalid <= rand_rd;
      if (rand_rd) acc_rdata <= rd_data[acc_col];
    end
  end

  fpm_serial #(.COLS(COLS)) u_serial (
    .clk(clk), .rst_n(rst_n), .load(xfer_req), .row_in(rd_data),
    .shift_en(shift_en), .vid_out(vid_out), .empty(xfer_flag)
  );

  // R8: the array serves at most one client per cycle, and the fill walker agrees with the arbiter
  assert_one_client_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_req, fill_step, acc_grant}));
  // R7: no single-bit access while a rectangle is running
  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_busy |-> !acc_grant);
  // R3: a granted read produces data in the next cycle
  assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant && !acc_we |=> acc_rvalid);
  // R3: no data without a read grant
  assert_no_stray_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && !acc_we) |=> !acc_rvalid);

endmodule

// File: tb/frame_plane_mem_bench.sv
module frame_plane_mem_bench;
  localparam int RB = 4;
  localparam int CB = 4;
  localparam int NR = 1 << RB;
  localparam int NC = 1 << CB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 0, acc_we = 0, acc_wdata = 0;
  logic [RB-1:0] acc_row = '0;
  logic [CB-1:0] acc_col = '0;
  logic acc_grant, acc_rdata, acc_rvalid;
  logic fill_start = 0, fill_val = 0;
  logic [CB-1:0] fill_x0 = '0, fill_x1 = '0;
  logic [RB-1:0] fill_y0 = '0, fill_y1 = '0;
  logic fill_busy;
  logic xfer_req = 0, shift_en = 0;
  logic [RB-1:0] xfer_row = '0;
  logic vid_out, xfer_flag;

  int compared = 0;
  int mismatched = 0;
  bit model [NR][NC];
  bit exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  frame_plane_mem #(.ROW_BITS(RB), .COL_BITS(CB)) u_frame_plane_mem (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_row(acc_row), .acc_col(acc_col), .acc_wdata(acc_wdata),
    .acc_grant(acc_grant), .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .fill_start(fill_start), .fill_x0(fill_x0), .fill_y0(fill_y0),
    .fill_x1(fill_x1), .fill_y1(fill_y1), .fill_val(fill_val),
    .fill_busy(fill_busy), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .shift_en(shift_en), .vid_out(vid_out), .xfer_flag(xfer_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop expected read bits as results appear
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) check("R3 unexpected rvalid", 1, 0);
      else check(tag_q.pop_front(), int'(acc_rdata), int'(exp_q.pop_front()));
    end
  end

  // driver: single-bit access, held until granted
  task automatic access(input bit we, input int r, input int c, input bit wd, input string tag);
    @(negedge clk);
    acc_req = 1; acc_we = we; acc_row = RB'(r); acc_col = CB'(c); acc_wdata = wd;
    #1;
    while (!acc_grant) begin @(negedge clk); #1; end
    if (we) model[r][c] = wd;
    else begin exp_q.push_back(model[r][c]); tag_q.push_back(tag); end
    @(posedge clk); #1;
    acc_req = 0;
  endtask

  task automatic model_fill(input int xa, input int ya, input int xb, input int yb, input bit v);
    for (int y = (ya < yb ? ya : yb); y <= (ya < yb ? yb : ya); y++)
      for (int x = (xa < xb ? xa : xb); x <= (xa < xb ? xb : xa); x++)
        model[y][x] = v;
  endtask

  task automatic pulse_fill(input int xa, input int ya, input int xb, input int yb, input bit v);
    @(negedge clk);
    fill_start = 1; fill_x0 = CB'(xa); fill_y0 = RB'(ya);
    fill_x1 = CB'(xb); fill_y1 = RB'(yb); fill_val = v;
    @(negedge clk);
    fill_start = 0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (fill_busy) begin n++; @(negedge clk); end
  endtask

  task automatic run_fill(input int xa, input int ya, input int xb, input int yb, input bit v,
                          input string tag);
    int n;
    int h;
    h = (ya > yb ? ya - yb : yb - ya) + 1;
    pulse_fill(xa, ya, xb, yb, v);
    model_fill(xa, ya, xb, yb, v);
    check({tag, " busy rises"}, int'(fill_busy), 1);
    wait_busy(n);
    check({tag, " busy length"}, n, h);
  endtask

  task automatic read_row(input int r, input string tag);
    for (int c = 0; c < NC; c++) access(0, r, c, 0, tag);
  endtask

  task automatic stream_row(input int r);
    @(negedge clk);
    xfer_req = 1; xfer_row = RB'(r);
    @(negedge clk);
    xfer_req = 0;
    check("R10 flag falls", int'(xfer_flag), 0);
    for (int c = 0; c < NC; c++) begin
      check("R9 serial bit", int'(vid_out), int'(model[r][c]));
      if (c < NC - 1) check("R10 flag low while draining", int'(xfer_flag), 0);
      shift_en = 1;
      @(negedge clk);
    end
    shift_en = 0;
    check("R10 flag after last shift", int'(xfer_flag), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    bit hold;
    for (int r = 0; r < NR; r++) for (int c = 0; c < NC; c++) model[r][c] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", int'(fill_busy), 0);
    check("R1 rvalid", int'(acc_rvalid), 0);
    check("R1 flag", int'(xfer_flag), 1);
    rst_n = 1;
    @(negedge clk);
    check("R1 flag after release", int'(xfer_flag), 1);

    // R4 R5: clear the whole plane
    run_fill(0, 0, NC - 1, NR - 1, 0, "R5 full clear");

    // R2 R3: single bits and their neighbours
    access(1, 3, 5, 1, "R2");
    access(1, 3, 6, 1, "R2");
    access(1, 3, 6, 0, "R2");
    access(1, 9, 0, 1, "R2");
    access(1, 9, NC - 1, 1, "R2");
    read_row(3, "R2 row 3");
    read_row(9, "R3 row 9");
    access(0, 2, 5, 0, "R2 neighbour row");

    // R4: rectangle with corners in normal and swapped order
    run_fill(2, 4, 7, 6, 1, "R5 rect A");
    run_fill(12, 8, 5, 5, 1, "R5 rect B swapped");
    run_fill(6, 5, 3, 5, 0, "R5 single row clear");
    for (int r = 3; r <= 9; r++) read_row(r, "R4 region");

    // R9 R10: stream rows out
    stream_row(5);
    stream_row(9);
    // R10: strobes on empty register
    hold = vid_out;
    shift_en = 1;
    repeat (3) @(negedge clk);
    shift_en = 0;
    check("R10 empty vid stable", int'(vid_out), int'(hold));
    check("R10 empty flag stays", int'(xfer_flag), 1);

    // R7: write during a rectangle is held off, then overrides it
    pulse_fill(0, 10, 15, 12, 1);
    model_fill(0, 10, 15, 12, 1);
    acc_req = 1; acc_we = 1; acc_row = 4'd11; acc_col = 4'd4; acc_wdata = 0;
    n = 0;
    while (fill_busy) begin
      #1;
      check("R7 no grant while busy", int'(acc_grant), 0);
      n++;
      @(negedge clk);
    end
    #1;
    check("R7 grant after fill", int'(acc_grant), 1);
    model[11][4] = 0;
    @(posedge clk); #1; acc_req = 0;
    check("R5 busy length with held write", n, 3);
    read_row(11, "R7 override");

    // R8: row copy during rectangle pauses it one cycle
    pulse_fill(0, 13, 3, 15, 0);
    model_fill(0, 13, 3, 15, 0);
    xfer_req = 1; xfer_row = 4'd11;
    @(negedge clk);
    xfer_req = 0;
    wait_busy(n);
    check("R8 stalled busy length", n + 1, 4);
    for (int c = 0; c < NC; c++) begin
      check("R9 row copied mid-fill", int'(vid_out), int'(model[11][c]));
      shift_en = 1;
      @(negedge clk);
    end
    shift_en = 0;
    read_row(13, "R8 fill result");

    // R8: random request loses to a row copy
    @(negedge clk);
    acc_req = 1; acc_we = 1; acc_row = 4'd0; acc_col = 4'd0; acc_wdata = 1;
    xfer_req = 1; xfer_row = 4'd3;
    #1;
    check("R8 grant blocked by copy", int'(acc_grant), 0);
    @(negedge clk);
    xfer_req = 0;
    #1;
    check("R8 grant next cycle", int'(acc_grant), 1);
    model[0][0] = 1;
    @(posedge clk); #1; acc_req = 0;
    check("R9 copy bit 0", int'(vid_out), int'(model[3][0]));
    access(0, 0, 0, 0, "R8 delayed write");

    // R6: start while busy is ignored
    pulse_fill(0, 0, 1, 1, 1);
    model_fill(0, 0, 1, 1, 1);
    fill_start = 1; fill_x0 = 4'd10; fill_y0 = 4'd0; fill_x1 = 4'd14; fill_y1 = 4'd2;
    fill_val = 1;
    @(negedge clk);
    fill_start = 0;
    wait_busy(n);
    check("R6 busy unchanged", n + 1, 2);
    read_row(0, "R6 ignored region row 0");
    read_row(2, "R6 ignored region row 2");

    repeat (4) @(negedge clk);
    check("R3 queue drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule